// File: doc/BRIEF.md
# Registered 32-bit Integer ALU with Signed-Overflow Trap Flag

This block is the integer execute unit of a load-store RISC core. Each operation it accepts carries two operands, a constant shift amount and a 5-bit operation code. It returns one result word and a flag that tells the core to take an overflow exception. The operations are:

- two's-complement add and subtract, in a trapping form and a non-trapping form
- the four bitwise logic operations
- left, logical-right and arithmetic-right shifts, by a constant amount or by an amount held in a register
- signed and unsigned set-on-less-than
- upper-half immediate placement

The immediate forms of add, the logic operations and set-on-less-than reuse the same codes. Upstream logic extends the immediate into operand B: sign extension for arithmetic and compares, zero extension for AND, OR and XOR.

The arithmetic is combinational. One output register stage, with a valid/ready handshake on both sides, sits after it. An operation is accepted when `in_valid` and `in_ready` are both high on a rising clock edge. `in_ready` is high while the output register is empty, or while the consumer is taking its content in the same cycle. Once `out_valid` is high, the result and the flag stay unchanged until `out_ready` is seen high at a clock edge. Accepted operations appear at the output one clock after acceptance.

Top module: `intalu_top`

## Requirements
- R1: Codes 0 (ADD) and 2 (SUB) give A+B and A−B modulo 2^32. They raise `out_ovf` exactly when A and the effective B (B for add, ~B for subtract) have equal sign bits and the result's sign bit differs from A's.
- R2: Codes 1 (ADDU) and 3 (SUBU) give the same result as codes 0 and 2 and never raise `out_ovf`. No other code raises `out_ovf` either.
- R3: Codes 4 to 7 give A AND B, A OR B, A XOR B and NOT(A OR B) respectively.
- R4: Codes 8, 9 and 10 shift operand B by `in_shamt`: left with zero fill, right with zero fill, and right with copies of B[31] filling the vacated bits.
- R5: Codes 11, 12 and 13 perform the same three shifts of B, but by the amount in A[4:0]. Bits A[31:5] have no effect.
- R6: Code 14 gives 1 when A < B as signed numbers, and 0 otherwise. Code 15 makes the same comparison with both operands taken as unsigned numbers. Bits 31:1 of either result are zero.
- R7: Code 16 gives {B[15:0], 16'h0000}.
- R8: Codes 17 to 31 give a result of zero with `out_ovf` low.
- R9: An operation transfers when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` equals (not `out_valid`) or `out_ready`.
- R10: While `out_valid` is high and `out_ready` is low, `out_result` and `out_ovf` hold their values and `out_valid` stays high.
- R11: While `rst_n` is low, `out_valid` is low. The output register is empty after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The block can take an operation this cycle |
| in_op | input | 5 | Operation code (see requirements) |
| in_a | input | 32 | Operand A; supplies the variable shift amount |
| in_b | input | 32 | Operand B; the shifted value and the upper-immediate source |
| in_shamt | input | 5 | Constant shift amount |
| out_valid | output | 1 | Result register holds an operation |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Result word |
| out_ovf | output | 1 | Overflow exception request |

## Verification
The add and subtract checks use operand pairs at the signed boundary: largest positive plus one, most negative minus one, minus one plus one, and subtractions of mixed signs. Each pair is issued under both the trapping and the non-trapping code. This shows that the sum is shared between the two forms and that only the trapping form raises the flag. The shift checks use amounts of 0, 4 and 31 on a negative operand, which exposes any mix-up between zero fill and sign fill. Variable shifts are given an A operand with high bits set, to show that only its low five bits count. Set-on-less-than is tried with −1 against 1, which separates the signed compare from the unsigned one. A held-output case checks the back-pressure rules.

// File: rtl/intalu_pkg.sv
package intalu_pkg;
  localparam int unsigned OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,
    OP_ADDU = 5'd1,
    OP_SUB  = 5'd2,
    OP_SUBU = 5'd3,
    OP_AND  = 5'd4,
    OP_OR   = 5'd5,
    OP_XOR  = 5'd6,
    OP_NOR  = 5'd7,
    OP_SLL  = 5'd8,
    OP_SRL  = 5'd9,
    OP_SRA  = 5'd10,
    OP_SLLV = 5'd11,
    OP_SRLV = 5'd12,
    OP_SRAV = 5'd13,
    OP_SLT  = 5'd14,
    OP_SLTU = 5'd15,
    OP_LUI  = 5'd16
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RLOG  = 2'd1,
    SH_RARI  = 2'd2
  } shift_kind_e;
endpackage

// File: rtl/intalu_addsub.sv
module intalu_addsub #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             subtract,
  input  logic             trapping,
  output logic [WIDTH-1:0] sum,
  output logic             ovf,
  output logic             lt_signed,
  output logic             lt_unsigned
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;

  always_comb begin
    b_eff = subtract ? ~b : b;
    sum   = a + b_eff + {{(WIDTH-1){1'b0}}, subtract};
    ovf   = trapping && (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
  end

  assign lt_signed   = $signed(a) < $signed(b);
  assign lt_unsigned = a < b;
endmodule

// File: rtl/intalu_logic.sv
module intalu_logic #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [1:0]       sel,
  output logic [WIDTH-1:0] y
);
  always_comb begin
    unique case (sel)
      2'd0:    y = a & b;
      2'd1:    y = a | b;
      2'd2:    y = a ^ b;
      default: y = ~(a | b);
    endcase
  end
endmodule

// File: rtl/intalu_shift.sv
module intalu_shift #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned SHW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] val,
  input  logic [SHW-1:0]   amt,
  input  intalu_pkg::shift_kind_e kind,
  output logic [WIDTH-1:0] y
);
  import intalu_pkg::*;

  always_comb begin
    unique case (kind)
      SH_LEFT: y = val << amt;
      SH_RLOG: y = val >> amt;
      SH_RARI: y = $unsigned($signed(val) >>> amt);
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/intalu_core.sv
module intalu_core #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned SHW  = $clog2(WIDTH),
  localparam int unsigned HALF = WIDTH / 2
) (
  input  logic [intalu_pkg::OP_W-1:0] op,
  input  logic [WIDTH-1:0]            a,
  input  logic [WIDTH-1:0]            b,
  input  logic [SHW-1:0]              shamt,
  output logic [WIDTH-1:0]            result,
  output logic                        ovf
);
  import intalu_pkg::*;

  logic [WIDTH-1:0] as_sum, lg_y, sh_y;
  logic             as_ovf, lt_s, lt_u, is_sub, is_trap, is_var;
  logic [SHW-1:0]   sh_amt;
  shift_kind_e      sh_kind;

  assign is_sub  = (op == OP_SUB) || (op == OP_SUBU);
  assign is_trap = (op == OP_ADD) || (op == OP_SUB);
  assign is_var  = (op == OP_SLLV) || (op == OP_SRLV) || (op == OP_SRAV);
  assign sh_amt  = is_var ? a[SHW-1:0] : shamt;

  always_comb begin
    unique case (op)
      OP_SRL, OP_SRLV: sh_kind = SH_RLOG;
      OP_SRA, OP_SRAV: sh_kind = SH_RARI;
      default:         sh_kind = SH_LEFT;
    endcase
  end

  intalu_addsub #(.WIDTH(WIDTH)) addsub_i (
    .a(a), .b(b), .subtract(is_sub), .trapping(is_trap),
    .sum(as_sum), .ovf(as_ovf), .lt_signed(lt_s), .lt_unsigned(lt_u)
  );

  intalu_logic #(.WIDTH(WIDTH)) logic_i (
    .a(a), .b(b), .sel(op[1:0]), .y(lg_y)
  );

  intalu_shift #(.WIDTH(WIDTH)) shift_i (
    .val(b), .amt(sh_amt), .kind(sh_kind), .y(sh_y)
  );

  always_comb begin
    result = '0;
    ovf    = 1'b0;
    case (op)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: begin
        result = as_sum;
        ovf    = as_ovf;
      end
      OP_AND, OP_OR, OP_XOR, OP_NOR:    result = lg_y;
      OP_SLL, OP_SRL, OP_SRA,
      OP_SLLV, OP_SRLV, OP_SRAV:        result = sh_y;
      OP_SLT:  result = {{(WIDTH-1){1'b0}}, lt_s};
      OP_SLTU: result = {{(WIDTH-1){1'b0}}, lt_u};
      OP_LUI:  result = {b[HALF-1:0], {HALF{1'b0}}};
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/intalu_top.sv
module intalu_top #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned SHW  = $clog2(WIDTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [intalu_pkg::OP_W-1:0] in_op,
  input  logic [WIDTH-1:0]            in_a,
  input  logic [WIDTH-1:0]            in_b,
  input  logic [SHW-1:0]              in_shamt,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [WIDTH-1:0]            out_result,
  output logic                        out_ovf
);
  logic [WIDTH-1:0] core_result;
  logic             core_ovf;
  logic             accept;

  intalu_core #(.WIDTH(WIDTH)) core_i (
    .op(in_op), .a(in_a), .b(in_b), .shamt(in_shamt),
    .result(core_result), .ovf(core_ovf)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_ovf    <= 1'b0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_result <= core_result;
      out_ovf    <= core_ovf;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/intalu_chk.sv
module intalu_chk #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned SHW  = $clog2(WIDTH),
  localparam int unsigned HALF = WIDTH / 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        in_valid,
  input logic                        in_ready,
  input logic [intalu_pkg::OP_W-1:0] in_op,
  input logic [WIDTH-1:0]            in_a,
  input logic [WIDTH-1:0]            in_b,
  input logic [SHW-1:0]              in_shamt,
  input logic                        out_valid,
  input logic                        out_ready,
  input logic [WIDTH-1:0]            out_result,
  input logic                        out_ovf
);
  import intalu_pkg::*;

  logic fire;
  assign fire = in_valid && in_ready;

  assert_unsigned_no_ovf_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (in_op == OP_ADDU || in_op == OP_SUBU) |=> !out_ovf);

  assert_nor_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op == OP_NOR |=> out_result == ~($past(in_a) | $past(in_b)));

  assert_slt_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (in_op == OP_SLT || in_op == OP_SLTU) |=> out_result[WIDTH-1:1] == '0);

  assert_upper_imm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op == OP_LUI |=> out_result == {$past(in_b[HALF-1:0]), {HALF{1'b0}}});

  assert_unused_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op > OP_LUI |=> out_result == '0 && !out_ovf);

  assert_accept_shows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_ovf));
endmodule

bind intalu_top intalu_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_shamt(in_shamt),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_result(out_result), .out_ovf(out_ovf)
);

// File: tb/intalu_tb.sv
module intalu_top_tb_top;
  localparam int unsigned CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_op = '0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic [4:0]  in_shamt = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_ovf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intalu_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_shamt(in_shamt),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_ovf(out_ovf)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Issue one operation, wait for its capture, check result and flag.
  task automatic run_op(input string req, input logic [4:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [4:0] sh,
                        input logic [31:0] exp_res, input logic exp_ovf);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_shamt = sh;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check({req, " result"}, out_result, exp_res);
    check({req, " ovf"}, {31'd0, out_ovf}, {31'd0, exp_ovf});
  endtask

  task automatic test_reset;
    check("R11 out_valid in reset", {31'd0, out_valid}, 32'd0);
    check("R9 in_ready in reset", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic test_arith;
    run_op("R1 add max+1",   5'd0, 32'h7FFF_FFFF, 32'h1, 0, 32'h8000_0000, 1'b1);
    run_op("R2 addu max+1",  5'd1, 32'h7FFF_FFFF, 32'h1, 0, 32'h8000_0000, 1'b0);
    run_op("R1 add -1+1",    5'd0, 32'hFFFF_FFFF, 32'h1, 0, 32'h0, 1'b0);
    run_op("R1 sub min-1",   5'd2, 32'h8000_0000, 32'h1, 0, 32'h7FFF_FFFF, 1'b1);
    run_op("R2 subu min-1",  5'd3, 32'h8000_0000, 32'h1, 0, 32'h7FFF_FFFF, 1'b0);
    run_op("R1 sub 5-(-3)",  5'd2, 32'h5, 32'hFFFF_FFFD, 0, 32'h8, 1'b0);
    run_op("R1 sub max-(-1)",5'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, 32'h8000_0000, 1'b1);
  endtask

  task automatic test_logic;
    run_op("R3 and", 5'd4, 32'hF0F0_1234, 32'hFF00_FF00, 0, 32'hF000_1200, 1'b0);
    run_op("R3 or",  5'd5, 32'hF0F0_1234, 32'hFF00_FF00, 0, 32'hFFF0_FF34, 1'b0);
    run_op("R3 xor", 5'd6, 32'hF0F0_1234, 32'hFF00_FF00, 0, 32'h0FF0_ED34, 1'b0);
    run_op("R3 nor", 5'd7, 32'hF0F0_1234, 32'hFF00_FF00, 0, 32'h000F_00CB, 1'b0);
  endtask

  task automatic test_shift;
    run_op("R4 sll 4",   5'd8,  32'h0, 32'h8000_00F1, 5'd4,  32'h0000_0F10, 1'b0);
    run_op("R4 srl 4",   5'd9,  32'h0, 32'h8000_00F1, 5'd4,  32'h0800_000F, 1'b0);
    run_op("R4 sra 4",   5'd10, 32'h0, 32'h8000_00F1, 5'd4,  32'hF800_000F, 1'b0);
    run_op("R4 sra 31",  5'd10, 32'h0, 32'h8000_0000, 5'd31, 32'hFFFF_FFFF, 1'b0);
    run_op("R4 srl 0",   5'd9,  32'h0, 32'h8000_00F1, 5'd0,  32'h8000_00F1, 1'b0);
    run_op("R5 sllv a=0xFFFFFFE4", 5'd11, 32'hFFFF_FFE4, 32'h0000_0003, 5'd0, 32'h0000_0030, 1'b0);
    run_op("R5 srlv a=0x25",       5'd12, 32'h0000_0025, 32'h8000_0000, 5'd9, 32'h0400_0000, 1'b0);
    run_op("R5 srav a=0x3F",       5'd13, 32'h0000_003F, 32'h8000_0000, 5'd0, 32'hFFFF_FFFF, 1'b0);
  endtask

  task automatic test_compare_lui;
    run_op("R6 slt -1<1",  5'd14, 32'hFFFF_FFFF, 32'h1, 0, 32'h1, 1'b0);
    run_op("R6 sltu -1<1", 5'd15, 32'hFFFF_FFFF, 32'h1, 0, 32'h0, 1'b0);
    run_op("R6 slt 3<3",   5'd14, 32'h3, 32'h3, 0, 32'h0, 1'b0);
    run_op("R6 sltu 2<9",  5'd15, 32'h2, 32'h9, 0, 32'h1, 1'b0);
    run_op("R7 lui",       5'd16, 32'h1234_5678, 32'hABCD_BEEF, 0, 32'hBEEF_0000, 1'b0);
    run_op("R8 code 20",   5'd20, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 5'd3, 32'h0, 1'b0);
    run_op("R8 code 31",   5'd31, 32'hFFFF_FFFF, 32'h1, 5'd1, 32'h0, 1'b0);
  endtask

  task automatic test_backpressure;
    run_op("R9 first item", 5'd1, 32'h10, 32'h20, 0, 32'h30, 1'b0);
    out_ready = 1'b0;
    #1;
    check("R9 in_ready low when full", {31'd0, in_ready}, 32'd0);
    in_valid = 1'b1; in_op = 5'd0; in_a = 32'h7FFF_FFFF; in_b = 32'h7FFF_FFFF;
    @(posedge clk); @(negedge clk);
    check("R10 held valid", {31'd0, out_valid}, 32'd1);
    check("R10 held result", out_result, 32'h30);
    check("R10 held ovf", {31'd0, out_ovf}, 32'd0);
    out_ready = 1'b1;
    #1;
    check("R9 in_ready with out_ready", {31'd0, in_ready}, 32'd1);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    check("R9 second result", out_result, 32'hFFFF_FFFE);
    check("R1 second ovf", {31'd0, out_ovf}, 32'd1);
    @(posedge clk); @(negedge clk);
    check("R9 drained", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 empty after reset", {31'd0, out_valid}, 32'd0);
    test_arith();
    test_logic();
    test_shift();
    test_compare_lui();
    test_backpressure();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule